// File: doc/BRIEF.md
# Bit Error Tester Lock and Error Accounting Controller

This block sits in the receive half of a bit error rate tester, after bit-clock recovery. It is strobed once per recovered bit. On each strobe it sees three inputs: the received bit, the locally generated reference bit, and a flag from the parallel state comparator that says whether the receiver's pattern state agrees with the incoming one. Before lock, it counts an unbroken run of agreeing strobes. When the run reaches a programmable length, it declares lock. From then on it forces both parallel state words seen by the comparator to zero, so the comparator keeps reporting agreement.

While locked, every bit is tallied and every disagreement between the received and reference bits is tallied as an error. The bits are grouped into fixed windows. If too many errors fall inside one window, the controller treats the alignment as lost. It then drops lock, releases the forced-zero gating and raises a search request so that acquisition starts again from an empty run. The error and bit totals are saturating counters. Software or a higher-level sequencer clears them with a synchronous pulse.

Top module: `bert_sync_ctrl`

## Requirements
- R1: After a synchronous reset, `locked` and `force_zero` are 0, `search_req` is 1, and both totals are 0.
- R2: In the acquiring state, lock is declared at the clock edge of the `lock_target`-th consecutive strobe (`bit_en`=1) with `state_match`=1. A `lock_target` of 0 behaves as 1.
- R3: A strobe with `state_match`=0 before the run reaches `lock_target` empties the run, so `lock_target` further consecutive matches are needed.
- R4: `force_zero` follows `locked`. While it is 1, `cmp_rx_state` and `cmp_ref_state` are all zeros. While it is 0, they equal `rx_state` and `ref_state` unchanged.
- R5: While locked, `state_match` has no effect on lock.
- R6: Totals change only while locked. Each strobe adds 1 to `bit_total`, and it adds 1 to `err_total` when `rx_bit` differs from `ref_bit`. Strobes in the acquiring state change neither total.
- R7: Locked operation is split into windows of WIN_LEN strobes (default 100). The first window starts at the strobe after lock. A window holding at most ERR_LIMIT errors (default 30) leaves lock in place, and each new window starts with zero errors.
- R8: The strobe that carries error number ERR_LIMIT+1 within one window drops `locked` at that edge. That error is still counted in the totals. `search_req` returns to 1, and reacquisition needs a fresh full run.
- R9: `clr_totals`=1 zeroes both totals at the next edge, even when a counted strobe arrives in the same cycle. It does not affect lock.
- R10: Both totals saturate at 2^TOT_W-1 and do not wrap.
- R11: Cycles with `bit_en`=0 change neither lock nor the totals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per recovered bit |
| rx_bit | input | 1 | Received bit |
| ref_bit | input | 1 | Local reference bit |
| state_match | input | 1 | Parallel state comparator agreement flag |
| lock_target | input | RUN_W | Consecutive matches needed for lock |
| clr_totals | input | 1 | Synchronous clear of both totals |
| rx_state | input | STATE_W | Received parallel state word |
| ref_state | input | STATE_W | Reference parallel state word |
| cmp_rx_state | output | STATE_W | Gated received word for the comparator |
| cmp_ref_state | output | STATE_W | Gated reference word for the comparator |
| locked | output | 1 | Lock declared |
| force_zero | output | 1 | Comparator input gating active |
| search_req | output | 1 | Synchronization search requested |
| err_total | output | TOT_W | Saturating error count |
| bit_total | output | TOT_W | Saturating bit count |

## Verification
A run counter stuck one step off shows up as `locked` rising one strobe early or late against a known match pattern, so it is caught at the lock edge itself. A window counter that drifts or fails to restart moves the strobe at which lock falls. That is seen by placing the error ERR_LIMIT+1 exactly at a window boundary and at the very next strobe. Gating or counting faults show at once on the comparator outputs or the totals, while a missed saturation shows only on a narrow-width instance after a few dozen strobes.

// File: rtl/bert_sync_pkg.sv
package bert_sync_pkg;

    // Controller phase: hunting for a run of matches, or measuring.
    typedef enum logic [0:0] {
        SYNC_ACQ  = 1'b0,
        SYNC_LOCK = 1'b1
    } sync_state_e;

    // Defaults shared by the top and its checker.
    localparam int DEF_WIN_LEN   = 100;
    localparam int DEF_ERR_LIMIT = 30;
    localparam int DEF_TOT_W     = 32;
    localparam int DEF_RUN_W     = 8;
    localparam int DEF_STATE_W   = 8;

    // Per-strobe bit event presented to the accounting logic.
    typedef struct packed {
        logic strobe;
        logic err;
    } bit_evt_t;

endpackage

// File: rtl/bert_run_counter.sv
module bert_run_counter
    import bert_sync_pkg::*;
#(
    parameter int RUN_W = DEF_RUN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             match,
    input  logic [RUN_W-1:0] target,
    input  logic             loss,
    output logic             locked
);

    sync_state_e      st_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W:0]   run_inc;
    logic             run_done;

    // Run never exceeds target-1 in acquisition, so the increment fits.
    assign run_inc  = {1'b0, run_q} + {{RUN_W{1'b0}}, 1'b1};
    assign run_done = run_inc >= {1'b0, target};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SYNC_ACQ;
            run_q <= '0;
        end else begin
            unique case (st_q)
                SYNC_ACQ: begin
                    if (strobe) begin
                        if (!match) begin
                            run_q <= '0;
                        end else if (run_done) begin
                            st_q  <= SYNC_LOCK;
                            run_q <= '0;
                        end else begin
                            run_q <= run_inc[RUN_W-1:0];
                        end
                    end
                end
                SYNC_LOCK: begin
                    if (loss) begin
                        st_q  <= SYNC_ACQ;
                        run_q <= '0;
                    end
                end
                default: begin
                    st_q  <= SYNC_ACQ;
                    run_q <= '0;
                end
            endcase
        end
    end

    assign locked = (st_q == SYNC_LOCK);

endmodule

// File: rtl/bert_err_window.sv
module bert_err_window
    import bert_sync_pkg::*;
#(
    parameter int WIN_LEN   = DEF_WIN_LEN,
    parameter int ERR_LIMIT = DEF_ERR_LIMIT
) (
    input  logic     clk,
    input  logic     rst,
    input  bit_evt_t evt,
    input  logic     locked,
    output logic     loss
);

    localparam int WIN_W  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int ELIM_W = $clog2(ERR_LIMIT + 2);

    localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WIN_LEN - 1);
    localparam logic [ELIM_W-1:0] ERR_TOP  = ELIM_W'(ERR_LIMIT);

    logic [WIN_W-1:0]  win_bits_q;
    logic [ELIM_W-1:0] win_errs_q;

    // Loss fires on the strobe that would push the window past the limit.
    assign loss = locked && evt.strobe && evt.err && (win_errs_q == ERR_TOP);

    always_ff @(posedge clk) begin
        if (rst || !locked) begin
            win_bits_q <= '0;
            win_errs_q <= '0;
        end else if (evt.strobe) begin
            if (loss || (win_bits_q == WIN_LAST)) begin
                win_bits_q <= '0;
                win_errs_q <= '0;
            end else begin
                win_bits_q <= win_bits_q + WIN_W'(1);
                win_errs_q <= win_errs_q + ELIM_W'(evt.err);
            end
        end
    end

endmodule

// File: rtl/bert_sat_counter.sv
module bert_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != {W{1'b1}})) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/bert_sync_ctrl.sv
module bert_sync_ctrl
    import bert_sync_pkg::*;
#(
    parameter int STATE_W   = DEF_STATE_W,
    parameter int RUN_W     = DEF_RUN_W,
    parameter int WIN_LEN   = DEF_WIN_LEN,
    parameter int ERR_LIMIT = DEF_ERR_LIMIT,
    parameter int TOT_W     = DEF_TOT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  logic               rx_bit,
    input  logic               ref_bit,
    input  logic               state_match,
    input  logic [RUN_W-1:0]   lock_target,
    input  logic               clr_totals,
    input  logic [STATE_W-1:0] rx_state,
    input  logic [STATE_W-1:0] ref_state,
    output logic [STATE_W-1:0] cmp_rx_state,
    output logic [STATE_W-1:0] cmp_ref_state,
    output logic               locked,
    output logic               force_zero,
    output logic               search_req,
    output logic [TOT_W-1:0]   err_total,
    output logic [TOT_W-1:0]   bit_total
);

    bit_evt_t evt;
    logic     loss;
    logic     lock_q;

    assign evt.strobe = bit_en;
    assign evt.err    = rx_bit ^ ref_bit;

    bert_run_counter #(.RUN_W(RUN_W)) u_run (
        .clk    (clk),
        .rst    (rst),
        .strobe (bit_en),
        .match  (state_match),
        .target (lock_target),
        .loss   (loss),
        .locked (lock_q)
    );

    bert_err_window #(.WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT)) u_win (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .locked (lock_q),
        .loss   (loss)
    );

    bert_sat_counter #(.W(TOT_W)) u_bits (
        .clk (clk),
        .rst (rst),
        .clr (clr_totals),
        .inc (lock_q && evt.strobe),
        .cnt (bit_total)
    );

    bert_sat_counter #(.W(TOT_W)) u_errs (
        .clk (clk),
        .rst (rst),
        .clr (clr_totals),
        .inc (lock_q && evt.strobe && evt.err),
        .cnt (err_total)
    );

    assign locked        = lock_q;
    assign force_zero    = lock_q;
    assign search_req    = !lock_q;
    assign cmp_rx_state  = force_zero ? '0 : rx_state;
    assign cmp_ref_state = force_zero ? '0 : ref_state;

endmodule

// File: rtl/bert_sync_ctrl_chk.sv
module bert_sync_ctrl_chk #(
    parameter int STATE_W = 8,
    parameter int RUN_W   = 8,
    parameter int TOT_W   = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               bit_en,
    input logic               rx_bit,
    input logic               ref_bit,
    input logic               state_match,
    input logic [RUN_W-1:0]   lock_target,
    input logic               clr_totals,
    input logic [STATE_W-1:0] rx_state,
    input logic [STATE_W-1:0] ref_state,
    input logic [STATE_W-1:0] cmp_rx_state,
    input logic [STATE_W-1:0] cmp_ref_state,
    input logic               locked,
    input logic               force_zero,
    input logic               search_req,
    input logic [TOT_W-1:0]   err_total,
    input logic [TOT_W-1:0]   bit_total
);

    // R4: gated words are zero while forcing, pass-through otherwise.
    p_cmp_gate_r4: assert property (@(posedge clk) disable iff (rst)
        force_zero ? (cmp_rx_state == '0 && cmp_ref_state == '0)
                   : (cmp_rx_state == rx_state && cmp_ref_state == ref_state));

    // R2: lock only rises after a strobe carrying a match.
    p_lock_on_match_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(bit_en && state_match));

    // R8: lock only falls after a strobe carrying a bit error.
    p_loss_on_error_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(bit_en && (rx_bit != ref_bit)));

    // R6: errors never outnumber counted bits.
    p_err_le_bits_r6: assert property (@(posedge clk) disable iff (rst)
        err_total <= bit_total);

    // R6: totals hold while unlocked and not cleared.
    p_unlocked_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!locked && !clr_totals) |=> ($stable(err_total) && $stable(bit_total)));

    // R9: a clear leaves both totals at zero.
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr_totals |=> (err_total == '0 && bit_total == '0));

    // R11: idle cycles change nothing.
    p_idle_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (!bit_en && !clr_totals) |=>
            ($stable(locked) && $stable(err_total) && $stable(bit_total)));

    // R1: search request is the complement of lock in every cycle.
    p_search_flag_r1: assert property (@(posedge clk) disable iff (rst)
        search_req != locked);

    // lock_target is read only by the run counter; kept as a checker input.
    logic unused_ok;
    assign unused_ok = ^lock_target;

endmodule

bind bert_sync_ctrl bert_sync_ctrl_chk #(
    .STATE_W (STATE_W),
    .RUN_W   (RUN_W),
    .TOT_W   (TOT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bit_en        (bit_en),
    .rx_bit        (rx_bit),
    .ref_bit       (ref_bit),
    .state_match   (state_match),
    .lock_target   (lock_target),
    .clr_totals    (clr_totals),
    .rx_state      (rx_state),
    .ref_state     (ref_state),
    .cmp_rx_state  (cmp_rx_state),
    .cmp_ref_state (cmp_ref_state),
    .locked        (locked),
    .force_zero    (force_zero),
    .search_req    (search_req),
    .err_total     (err_total),
    .bit_total     (bit_total)
);

// File: tb/tb_bert_sync_ctrl.sv
module tb_bert_sync_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_en;
    logic        rx_bit;
    logic        ref_bit;
    logic        state_match;
    logic [7:0]  lock_target;
    logic        clr_totals;
    logic [7:0]  rx_state;
    logic [7:0]  ref_state;
    logic [7:0]  cmp_rx_state, cmp_ref_state;
    logic        locked, force_zero, search_req;
    logic [31:0] err_total, bit_total;
    logic [7:0]  s_cmp_rx, s_cmp_ref;
    logic        s_locked, s_force, s_search;
    logic [3:0]  s_err, s_bits;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    bert_sync_ctrl dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .ref_bit(ref_bit),
        .state_match(state_match), .lock_target(lock_target), .clr_totals(clr_totals),
        .rx_state(rx_state), .ref_state(ref_state),
        .cmp_rx_state(cmp_rx_state), .cmp_ref_state(cmp_ref_state),
        .locked(locked), .force_zero(force_zero), .search_req(search_req),
        .err_total(err_total), .bit_total(bit_total)
    );

    // Narrow-total copy on the same stimulus, for saturation.
    bert_sync_ctrl #(.TOT_W(4)) dut_sat (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .ref_bit(ref_bit),
        .state_match(state_match), .lock_target(lock_target), .clr_totals(clr_totals),
        .rx_state(rx_state), .ref_state(ref_state),
        .cmp_rx_state(s_cmp_rx), .cmp_ref_state(s_cmp_ref),
        .locked(s_locked), .force_zero(s_force), .search_req(s_search),
        .err_total(s_err), .bit_total(s_bits)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One strobed bit; returns at the falling edge after it was taken.
    task automatic send(input logic err, input logic match);
        @(negedge clk);
        bit_en      = 1'b1;
        rx_bit      = err;
        ref_bit     = 1'b0;
        state_match = match;
        @(negedge clk);
        bit_en      = 1'b0;
    endtask

    task automatic send_n(input int n, input int nerr, input logic match);
        for (int i = 0; i < n; i++) send(i < nerr, match);
    endtask

    task automatic t_reset();
        rst = 1'b1; bit_en = 1'b0; rx_bit = 1'b0; ref_bit = 1'b0;
        state_match = 1'b0; lock_target = 8'd5; clr_totals = 1'b0;
        rx_state = 8'hA5; ref_state = 8'h3C;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "locked", locked, 0);
        chk("R1", "force_zero", force_zero, 0);
        chk("R1", "search_req", search_req, 1);
        chk("R1", "err_total", err_total, 0);
        chk("R1", "bit_total", bit_total, 0);
        chk("R4", "cmp_rx pass", cmp_rx_state, 8'hA5);
        chk("R4", "cmp_ref pass", cmp_ref_state, 8'h3C);
    endtask

    task automatic t_idle_unlocked();
        state_match = 1'b1;
        repeat (10) @(negedge clk);
        chk("R11", "no lock without strobes", locked, 0);
    endtask

    task automatic t_acquire();
        send_n(4, 0, 1'b1);
        send(1'b0, 1'b0);
        send_n(4, 0, 1'b1);
        chk("R3", "run restarted after mismatch", locked, 0);
        send(1'b1, 1'b1);  // 5th match, error bit must not be counted
        chk("R2", "locked on 5th match", locked, 1);
        chk("R6", "no error counted pre-lock", err_total, 0);
        chk("R6", "no bit counted pre-lock", bit_total, 0);
        chk("R4", "force_zero", force_zero, 1);
        chk("R4", "cmp_rx zero", cmp_rx_state, 0);
        chk("R4", "cmp_ref zero", cmp_ref_state, 0);
        chk("R1", "search_req low", search_req, 0);
    endtask

    task automatic t_count_window();
        send_n(10, 3, 1'b0);  // state_match low throughout
        chk("R5", "match ignored while locked", locked, 1);
        chk("R6", "err_total", err_total, 3);
        chk("R6", "bit_total", bit_total, 10);
        @(negedge clk);
        rx_bit = 1'b1; state_match = 1'b0;
        repeat (5) @(negedge clk);
        chk("R11", "idle bits", bit_total, 10);
        chk("R11", "idle errs", err_total, 3);
        send_n(90, 27, 1'b0);
        chk("R7", "30 errors in window keep lock", locked, 1);
        chk("R6", "err_total 30", err_total, 30);
        chk("R6", "bit_total 100", bit_total, 100);
        chk("R10", "narrow bits saturate", s_bits, 15);
        chk("R10", "narrow errs saturate", s_err, 15);
    endtask

    task automatic t_loss();
        send_n(30, 30, 1'b1);
        chk("R7", "new window starts empty", locked, 1);
        send(1'b1, 1'b1);
        chk("R8", "31st error drops lock", locked, 0);
        chk("R8", "search_req", search_req, 1);
        chk("R8", "err_total incl. losing bit", err_total, 61);
        chk("R8", "bit_total", bit_total, 131);
        chk("R4", "cmp pass after loss", cmp_rx_state, 8'hA5);
        send_n(5, 5, 1'b0);
        chk("R6", "unlocked errs held", err_total, 61);
        chk("R6", "unlocked bits held", bit_total, 131);
        send(1'b0, 1'b1);
        chk("R8", "single match not enough", locked, 0);
    endtask

    task automatic t_target_zero();
        send(1'b0, 1'b0);
        lock_target = 8'd0;
        send(1'b0, 1'b1);
        chk("R2", "target 0 locks on one match", locked, 1);
    endtask

    task automatic t_clear();
        @(negedge clk);
        clr_totals = 1'b1; bit_en = 1'b1; rx_bit = 1'b1; ref_bit = 1'b0;
        @(negedge clk);
        clr_totals = 1'b0; bit_en = 1'b0;
        chk("R9", "clear beats increment errs", err_total, 0);
        chk("R9", "clear beats increment bits", bit_total, 0);
        chk("R9", "lock kept", locked, 1);
        send(1'b1, 1'b0);
        chk("R9", "count resumes errs", err_total, 1);
        chk("R9", "count resumes bits", bit_total, 1);
    endtask

    initial begin
        t_reset();
        t_idle_unlocked();
        t_acquire();
        t_count_window();
        t_loss();
        t_target_zero();
        t_clear();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule